// File: doc/BRIEF.md
# Sound Register Interface

This block is the processor-facing register file of a four-channel sound generator. It stores the byte-wide channel and mixer control registers and a 16-byte waveform memory. Each register write is forwarded to the channel logic as a one-cycle strobe that carries the register index and the value to apply. A master power bit gates those writes, with exceptions that depend on the register and on a static style input. Reads return the stored byte with the unused or write-only bits forced to 1.

The waveform memory normally maps byte for byte onto the bus. While channel 3 is playing, bus accesses are redirected to the byte the channel is currently fetching, which is the wave position shifted right by one. In the older style a readable-window flag from the channel logic decides whether such an access goes through. The channel logic also supplies four per-channel active flags, and these appear in the low nibble of the master control readback.

Address map (6-bit offset): 0x00 sweep, 0x01/0x06 length-duty of channels 1/2, 0x02/0x07 envelope 1/2, 0x03/0x08/0x0D frequency-low 1/2/3, 0x04/0x09/0x0E/0x13 trigger 1/2/3/4, 0x0A ch3 DAC enable, 0x0B ch3 length, 0x0C ch3 level, 0x10 ch4 length, 0x11 ch4 envelope, 0x12 ch4 noise, 0x14 volume, 0x15 panning, 0x16 master control, 0x20-0x2F waveform bytes. Every other offset is unused.

Top module: `snd_regif`

## Requirements
- R1: After reset, reads return master control 0x80 | 0x70 | active flags, volume 0x77, panning 0xF3, sweep 0x80 and ch3 DAC enable 0x7F.
- R2: While the master power bit (bit 7 of offset 0x16) is 1, a write to any register from 0x00 to 0x15 stores the byte, and one cycle later fw_stb pulses with fw_idx equal to the offset and fw_val equal to the written byte.
- R3: A register read returns the stored byte ORed with its mask: 0x80 for sweep, 0x3F for the length-duty registers, 0xFF for frequency-low and for the ch3 and ch4 length registers, 0xBF for trigger registers, 0x7F for ch3 DAC enable, 0x9F for ch3 level and 0x00 for the others.
- R4: While power is 0, a write to a register from 0x00 to 0x15 produces no strobe and clears the stored byte to 0, except in the cases given in R5 and R6.
- R5: With style_new = 0 and power 0, writes to the ch3 and ch4 length registers (0x0B, 0x10) are still stored and strobed.
- R6: With style_new = 0 and power 0, a write to 0x01 or 0x06 strobes fw_val = data & 0x3F, and the stored byte becomes 0.
- R7: A write to 0x16 is always strobed with the full byte but stores only bit 7. On readback, bits 6:4 read 1 and bits 3:0 show ch_active.
- R8: When ch3_playing = 0, a waveform byte is read and written at offset - 0x20.
- R9: When ch3_playing = 1, a waveform read returns byte ch3_pos >> 1 if ch3_readable = 1 or style_new = 1, and 0xFF otherwise.
- R10: When ch3_playing = 1 and style_new = 0, a waveform write goes to byte ch3_pos >> 1 if ch3_readable = 1 and is dropped otherwise. With style_new = 1 it goes to the addressed byte.
- R11: Waveform writes take effect whatever the state of the power bit.
- R12: Unused offsets read 0xFF. Writes to them change nothing and produce no strobe.
- R13: rd_data is updated on the clock edge that samples bus_rd. fw_stb is high only in the cycle after the write and never without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| style_new | input | 1 | Static variant select: 0 older, 1 newer |
| bus_addr | input | 6 | Register or waveform offset |
| bus_wr | input | 1 | Write request this cycle |
| bus_rd | input | 1 | Read request this cycle |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ch_active | input | 4 | Per-channel active flags from channel logic |
| ch3_playing | input | 1 | Channel 3 is playing |
| ch3_pos | input | 5 | Channel 3 sample position |
| ch3_readable | input | 1 | Channel 3 fetch window open |
| fw_stb | output | 1 | Register write strobe to channel logic |
| fw_idx | output | 5 | Register index of the strobe |
| fw_val | output | 8 | Value delivered with the strobe |

## Verification
Both read data and the forwarded strobe arrive exactly one clock after the request. The bench drives each request on a falling edge, removes it on the next falling edge and samples the outputs at that point, which is half a cycle after the edge that registered them. A write check also confirms that the strobe is absent one cycle later. Channel-side inputs are set before a request and held across it, so the expected value worked out from them stays valid through the registering edge.

// File: rtl/snd_regif_pkg.sv
// Shared constants for the sound register interface: register offsets,
// readback masks, reset values and the valid-register decode.
// Assumes a 6-bit bus offset with control registers below 0x20.
package snd_regif_pkg;

    localparam int NREG = 23;

    localparam logic [4:0] R_SWEEP  = 5'h00;
    localparam logic [4:0] R_LEN1   = 5'h01;
    localparam logic [4:0] R_FLO1   = 5'h03;
    localparam logic [4:0] R_TRG1   = 5'h04;
    localparam logic [4:0] R_GAP0   = 5'h05;
    localparam logic [4:0] R_LEN2   = 5'h06;
    localparam logic [4:0] R_FLO2   = 5'h08;
    localparam logic [4:0] R_TRG2   = 5'h09;
    localparam logic [4:0] R_DAC3   = 5'h0A;
    localparam logic [4:0] R_LEN3   = 5'h0B;
    localparam logic [4:0] R_LVL3   = 5'h0C;
    localparam logic [4:0] R_FLO3   = 5'h0D;
    localparam logic [4:0] R_TRG3   = 5'h0E;
    localparam logic [4:0] R_GAP1   = 5'h0F;
    localparam logic [4:0] R_LEN4   = 5'h10;
    localparam logic [4:0] R_TRG4   = 5'h13;
    localparam logic [4:0] R_VOL    = 5'h14;
    localparam logic [4:0] R_PAN    = 5'h15;
    localparam logic [4:0] R_MASTER = 5'h16;

    // True for offsets that hold a control register.
    function automatic logic reg_valid(input logic [4:0] i);
        return (i <= R_MASTER) && (i != R_GAP0) && (i != R_GAP1);
    endfunction

    // Bits forced to 1 on readback.
    function automatic logic [7:0] reg_mask(input logic [4:0] i);
        case (i)
            R_SWEEP:                         return 8'h80;
            R_LEN1, R_LEN2:                  return 8'h3F;
            R_FLO1, R_FLO2, R_FLO3:          return 8'hFF;
            R_LEN3, R_LEN4:                  return 8'hFF;
            R_TRG1, R_TRG2, R_TRG3, R_TRG4:  return 8'hBF;
            R_DAC3:                          return 8'h7F;
            R_LVL3:                          return 8'h9F;
            R_MASTER:                        return 8'h70;
            default:                         return 8'h00;
        endcase
    endfunction

    // Stored value after reset.
    function automatic logic [7:0] reg_init(input logic [4:0] i);
        case (i)
            R_SWEEP:  return 8'h80;
            R_LEN1:   return 8'hBF;
            5'h02:    return 8'hF3;
            R_FLO1:   return 8'hF3;
            R_TRG1:   return 8'hBF;
            R_LEN2:   return 8'h3F;
            R_TRG2:   return 8'hBF;
            R_DAC3:   return 8'h7F;
            R_LEN3:   return 8'hFF;
            R_LVL3:   return 8'h9F;
            R_TRG3:   return 8'hBF;
            R_LEN4:   return 8'hFF;
            R_TRG4:   return 8'hBF;
            R_VOL:    return 8'h77;
            R_PAN:    return 8'hF3;
            R_MASTER: return 8'h80;
            default:  return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/snd_reg_bank.sv
// Control register storage with power gating and write forwarding.
// Decides per write what is stored and what is sent to the channel logic.
// Assumes wr_en is asserted only for offsets below 0x20.
module snd_reg_bank
    import snd_regif_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  style_new,
    input  logic                  wr_en,
    input  logic [4:0]            wr_idx,
    input  logic [7:0]            wr_val,
    output logic [NREG-1:0][7:0]  regs,
    output logic                  power_on,
    output logic                  fw_stb,
    output logic [4:0]            fw_idx,
    output logic [7:0]            fw_val
);

    logic       hit;
    logic [7:0] store_val;
    logic       send;
    logic [7:0] send_val;

    assign power_on = regs[R_MASTER][7];

    // Gating decision for the current write.
    always_comb begin
        hit       = wr_en && reg_valid(wr_idx);
        store_val = 8'h00;
        send      = 1'b0;
        send_val  = wr_val;
        if (wr_idx == R_MASTER) begin
            store_val = {wr_val[7], 7'b0};
            send      = 1'b1;
        end else if (power_on ||
                     (!style_new && (wr_idx == R_LEN3 || wr_idx == R_LEN4))) begin
            store_val = wr_val;
            send      = 1'b1;
        end else if (!style_new && (wr_idx == R_LEN1 || wr_idx == R_LEN2)) begin
            send      = 1'b1;
            send_val  = wr_val & 8'h3F;
        end
    end

    // One storage byte per register offset.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [4:0] IDX = 5'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= reg_init(IDX);
            else if (hit && wr_idx == IDX)
                regs[g] <= store_val;
        end
    end

    // Registered strobe toward the channel logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fw_stb <= 1'b0;
            fw_idx <= '0;
            fw_val <= '0;
        end else begin
            fw_stb <= hit && send;
            if (hit && send) begin
                fw_idx <= wr_idx;
                fw_val <= send_val;
            end
        end
    end

endmodule

// File: rtl/snd_wave_ram.sv
// Waveform byte store with playback-aware access redirection.
// Assumes pos counts samples, two samples per byte.
module snd_wave_ram #(
    parameter int WAVE_BYTES = 16,
    localparam int WA_W  = $clog2(WAVE_BYTES),
    localparam int POS_W = WA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_new,
    input  logic              wr_en,
    input  logic [WA_W-1:0]   addr,
    input  logic [7:0]        wdata,
    input  logic              playing,
    input  logic [POS_W-1:0]  pos,
    input  logic              readable,
    output logic [7:0]        rdata
);

    logic [7:0]      ram [WAVE_BYTES];
    logic [WA_W-1:0] pos_byte;
    logic            wr_ok;
    logic [WA_W-1:0] wr_at;

    assign pos_byte = pos[POS_W-1:1];

    // Choose where a write lands, if anywhere.
    always_comb begin
        wr_ok = 1'b1;
        wr_at = addr;
        if (playing && !style_new) begin
            wr_ok = readable;
            wr_at = pos_byte;
        end
    end

    // Byte storage, cleared on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAVE_BYTES; i++) ram[i] <= 8'h00;
        end else if (wr_en && wr_ok) begin
            ram[wr_at] <= wdata;
        end
    end

    // Read path with playback redirection.
    always_comb begin
        if (!playing)
            rdata = ram[addr];
        else if (readable || style_new)
            rdata = ram[pos_byte];
        else
            rdata = 8'hFF;
    end

endmodule

// File: rtl/snd_read_mux.sv
// Readback selection: masked registers, master status, waveform, unused.
// Purely combinational; the top registers its result.
module snd_read_mux
    import snd_regif_pkg::*;
(
    input  logic [5:0]            addr,
    input  logic [NREG-1:0][7:0]  regs,
    input  logic [7:0]            wave_rdata,
    input  logic [3:0]            ch_active,
    output logic [7:0]            data
);

    logic [4:0] idx;
    assign idx = addr[4:0];

    // Pick the byte for the addressed offset.
    always_comb begin
        data = 8'hFF;
        if (addr[5:4] == 2'b10)
            data = wave_rdata;
        else if (!addr[5] && reg_valid(idx)) begin
            if (idx == R_MASTER)
                data = {regs[R_MASTER][7], 3'b111, ch_active};
            else
                data = regs[idx] | reg_mask(idx);
        end
    end

endmodule

// File: rtl/snd_regif.sv
// Top of the sound register interface: address decode, register bank,
// waveform store and registered read port.
// Assumes at most one of bus_wr / bus_rd per cycle.
module snd_regif #(
    parameter int WAVE_BYTES = 16,
    localparam int WA_W  = $clog2(WAVE_BYTES),
    localparam int POS_W = WA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              style_new,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    input  logic [3:0]        ch_active,
    input  logic              ch3_playing,
    input  logic [POS_W-1:0]  ch3_pos,
    input  logic              ch3_readable,
    output logic              fw_stb,
    output logic [4:0]        fw_idx,
    output logic [7:0]        fw_val
);
    import snd_regif_pkg::*;

    logic [NREG-1:0][7:0] regs;
    logic                 power_on;
    logic                 wave_sel;
    logic [7:0]           wave_rdata;
    logic [7:0]           mux_data;

    assign wave_sel = (bus_addr[5:4] == 2'b10);

    snd_reg_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .style_new (style_new),
        .wr_en     (bus_wr && !bus_addr[5]),
        .wr_idx    (bus_addr[4:0]),
        .wr_val    (bus_wdata),
        .regs      (regs),
        .power_on  (power_on),
        .fw_stb    (fw_stb),
        .fw_idx    (fw_idx),
        .fw_val    (fw_val)
    );

    snd_wave_ram #(.WAVE_BYTES(WAVE_BYTES)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .style_new (style_new),
        .wr_en     (bus_wr && wave_sel),
        .addr      (bus_addr[WA_W-1:0]),
        .wdata     (bus_wdata),
        .playing   (ch3_playing),
        .pos       (ch3_pos),
        .readable  (ch3_readable),
        .rdata     (wave_rdata)
    );

    snd_read_mux u_mux (
        .addr       (bus_addr),
        .regs       (regs),
        .wave_rdata (wave_rdata),
        .ch_active  (ch_active),
        .data       (mux_data)
    );

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= 8'h00;
        else if (bus_rd)
            rd_data <= mux_data;
    end

endmodule

// File: rtl/snd_regif_checker.sv
// Temporal checks on the sound register interface, bound to the top.
module snd_regif_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       style_new,
    input logic [5:0] bus_addr,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic       ch3_playing,
    input logic       ch3_readable,
    input logic       power_on,
    input logic [7:0] rd_data,
    input logic       fw_stb,
    input logic [4:0] fw_idx,
    input logic [7:0] fw_val
);

    logic ctl_wr;
    assign ctl_wr = bus_wr && (bus_addr < 6'h16) &&
                    (bus_addr != 6'h05) && (bus_addr != 6'h0F);

    assert_stb_needs_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        fw_stb |-> $past(bus_wr));

    assert_unused_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr > 6'h16 && bus_addr < 6'h20) |=> !fw_stb);

    assert_off_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !power_on && style_new) |=> !fw_stb);

    assert_len_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !power_on && !style_new && (bus_addr == 6'h01 || bus_addr == 6'h06))
        |=> (fw_stb && fw_val[7:6] == 2'b00));

    assert_master_fwd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 6'h16) |=> (fw_stb && fw_idx == 5'h16));

    assert_master_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 6'h16) |=> (rd_data[6:4] == 3'b111));

    assert_flo_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 6'h03) |=> (rd_data == 8'hFF));

    assert_wave_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr[5:4] == 2'b10 && ch3_playing && !ch3_readable && !style_new)
        |=> (rd_data == 8'hFF));

endmodule

bind snd_regif snd_regif_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .style_new    (style_new),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .ch3_playing  (ch3_playing),
    .ch3_readable (ch3_readable),
    .power_on     (power_on),
    .rd_data      (rd_data),
    .fw_stb       (fw_stb),
    .fw_idx       (fw_idx),
    .fw_val       (fw_val)
);

// File: tb/snd_regif_bench.sv
module snd_regif_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       style_new = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] rd_data;
    logic [3:0] ch_active = 4'hA;
    logic       ch3_playing = 1'b0;
    logic [4:0] ch3_pos = '0;
    logic       ch3_readable = 1'b0;
    logic       fw_stb;
    logic [4:0] fw_idx;
    logic [7:0] fw_val;

    int total = 0;
    int bad = 0;

    logic [7:0] mreg [32];
    logic [7:0] mwave [16];

    snd_regif u_snd_regif (
        .clk(clk), .rst_n(rst_n), .style_new(style_new),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .rd_data(rd_data), .ch_active(ch_active),
        .ch3_playing(ch3_playing), .ch3_pos(ch3_pos),
        .ch3_readable(ch3_readable), .fw_stb(fw_stb), .fw_idx(fw_idx),
        .fw_val(fw_val)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit is_reg(input logic [5:0] a);
        return (a <= 6'h16) && (a != 6'h05) && (a != 6'h0F);
    endfunction

    function automatic logic [7:0] mask_of(input logic [5:0] a);
        case (a)
            6'h00: return 8'h80;
            6'h01, 6'h06: return 8'h3F;
            6'h03, 6'h08, 6'h0D, 6'h0B, 6'h10: return 8'hFF;
            6'h04, 6'h09, 6'h0E, 6'h13: return 8'hBF;
            6'h0A: return 8'h7F;
            6'h0C: return 8'h9F;
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
        for (int i = 0; i < 16; i++) mwave[i] = 8'h00;
        mreg[6'h00] = 8'h80; mreg[6'h01] = 8'hBF; mreg[6'h02] = 8'hF3;
        mreg[6'h03] = 8'hF3; mreg[6'h04] = 8'hBF; mreg[6'h06] = 8'h3F;
        mreg[6'h09] = 8'hBF; mreg[6'h0A] = 8'h7F; mreg[6'h0B] = 8'hFF;
        mreg[6'h0C] = 8'h9F; mreg[6'h0E] = 8'hBF; mreg[6'h10] = 8'hFF;
        mreg[6'h13] = 8'hBF; mreg[6'h14] = 8'h77; mreg[6'h15] = 8'hF3;
        mreg[6'h16] = 8'h80;
    endtask

    function automatic logic [7:0] exp_read(input logic [5:0] a);
        if (a[5:4] == 2'b10) begin
            if (!ch3_playing) return mwave[a[3:0]];
            if (ch3_readable || style_new) return mwave[ch3_pos[4:1]];
            return 8'hFF;
        end
        if (!is_reg(a)) return 8'hFF;
        if (a == 6'h16) return {mreg[6'h16][7], 3'b111, ch_active};
        return mreg[a] | mask_of(a);
    endfunction

    task automatic model_write(input logic [5:0] a, input logic [7:0] v,
                               output logic es, output logic [7:0] ev);
        logic pwr;
        pwr = mreg[6'h16][7];
        es = 1'b0; ev = v;
        if (a[5:4] == 2'b10) begin
            if (!ch3_playing || style_new) mwave[a[3:0]] = v;
            else if (ch3_readable) mwave[ch3_pos[4:1]] = v;
        end else if (is_reg(a)) begin
            if (a == 6'h16) begin
                mreg[a] = {v[7], 7'b0}; es = 1'b1;
            end else if (pwr || (!style_new && (a == 6'h0B || a == 6'h10))) begin
                mreg[a] = v; es = 1'b1;
            end else if (!style_new && (a == 6'h01 || a == 6'h06)) begin
                mreg[a] = 8'h00; es = 1'b1; ev = v & 8'h3F;
            end else begin
                mreg[a] = 8'h00;
            end
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] v, input string req);
        logic es;
        logic [7:0] ev;
        model_write(a, v, es, ev);
        @(negedge clk);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        chk({req, " strobe"}, {7'b0, fw_stb}, {7'b0, es});
        if (es) begin
            chk({req, " index"}, {3'b0, fw_idx}, {2'b0, a});
            chk({req, " value"}, fw_val, ev);
        end
    endtask

    task automatic rd(input logic [5:0] a, input string req);
        logic [7:0] e;
        e = exp_read(a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(req, rd_data, e);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(20240611);
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(6'h16, "R1 master");
        rd(6'h14, "R1 volume");
        rd(6'h15, "R1 panning");
        rd(6'h00, "R1 sweep");
        rd(6'h0A, "R1 dac3");

        // R2 / R3 powered writes and masks
        wr(6'h02, 8'h5A, "R2 env1");
        rd(6'h02, "R2 env1 read");
        wr(6'h03, 8'h00, "R3 flo1");
        rd(6'h03, "R3 flo1 read");
        wr(6'h04, 8'h00, "R3 trg1");
        rd(6'h04, "R3 trg1 read");
        wr(6'h01, 8'h00, "R3 len1");
        rd(6'h01, "R3 len1 read");
        wr(6'h0C, 8'h00, "R3 lvl3");
        rd(6'h0C, "R3 lvl3 read");
        @(negedge clk);
        chk("R13 strobe single cycle", {7'b0, fw_stb}, 8'h00);

        // R7 master write clears power
        ch_active = 4'h3;
        wr(6'h16, 8'h0F, "R7 master");
        rd(6'h16, "R7 master read");

        // R4 / R5 / R6 powered off, older style
        wr(6'h0B, 8'h12, "R5 len3 off");
        wr(6'h10, 8'h34, "R5 len4 off");
        wr(6'h02, 8'h44, "R4 env1 off");
        rd(6'h02, "R4 env1 cleared");
        wr(6'h01, 8'hC5, "R6 len1 off");
        rd(6'h01, "R6 len1 stored zero");
        wr(6'h06, 8'hFF, "R6 len2 off");

        // R12 unused offsets
        wr(6'h05, 8'h11, "R12 gap write");
        rd(6'h05, "R12 gap read");
        wr(6'h1A, 8'h22, "R12 high gap write");
        rd(6'h1A, "R12 high gap read");

        // R4 newer style, no exceptions
        style_new = 1'b1;
        wr(6'h0B, 8'h55, "R4 len3 off new");
        wr(6'h01, 8'h55, "R4 len1 off new");

        // R11 / R8 wave while off and idle
        wr(6'h21, 8'h9C, "R11 wave off");
        rd(6'h21, "R8 wave direct");

        // R9 / R10 playback redirection
        style_new = 1'b0;
        wr(6'h16, 8'h80, "R7 power on");
        ch3_playing = 1'b1; ch3_readable = 1'b0; ch3_pos = 5'd6;
        rd(6'h21, "R9 blocked read");
        wr(6'h25, 8'h77, "R10 dropped write");
        ch3_readable = 1'b1;
        wr(6'h25, 8'h66, "R10 redirected write");
        rd(6'h2A, "R9 redirected read");
        style_new = 1'b1; ch3_readable = 1'b0; ch3_pos = 5'd3;
        rd(6'h2F, "R9 newer read");
        wr(6'h2E, 8'hA5, "R10 newer write");
        ch3_playing = 1'b0;
        rd(6'h2E, "R10 newer landed");
        rd(6'h23, "R10 dropped check");

        // Random mix, both styles
        for (int n = 0; n < 600; n++) begin
            logic [5:0] a;
            logic [7:0] v;
            if (n == 300) style_new = ~style_new;
            a = 6'($urandom_range(0, 47));
            v = 8'($urandom);
            ch_active = 4'($urandom);
            ch3_playing = 1'($urandom);
            ch3_readable = 1'($urandom);
            ch3_pos = 5'($urandom);
            if (($urandom & 7) == 0) a = 6'h16;
            if ($urandom & 1) wr(a, v, "R2 random write");
            else rd(a, "R3 random read");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule